// File: doc/BRIEF.md
# Supply and Watchdog Reset Controller

This block drives a system reset line from three sources: a digitised supply-good flag, a shared chip-select pin that doubles as the watchdog input, and a free-running timebase strobe. Reset is asserted while the supply is bad. It stays asserted until the supply has been good for a fixed number of timebase ticks. The same hold-off applies after a power-up and after every brown-out.

A watchdog also asserts reset when the host stops toggling the chip-select pin. It fires whether the pin is stuck high or stuck low. A valid kick is a low pulse that lasts at least a minimum number of clock cycles. The pin passes through a two-flop synchroniser before this qualification. A two-bit period code, read from an external status register, selects one of three timeout lengths or turns the watchdog off. The watchdog is cleared while reset is asserted, and it starts counting when reset releases.

The `supply_ok` input is assumed to be synchronous to `clk`. All time constants are parameters counted in timebase ticks, and the kick width is counted in clock cycles. A parameter chooses the output polarity: active-low or active-high.

Top module: `sup_reset_ctrl`

## Requirements
- R1: While `rst_n` is low, reset is asserted. Once `rst_n` rises with `supply_ok` high and `tick` high every cycle, reset releases on the HOLD_TICKS-th clock edge (default 200).
- R2: On the first clock edge that sees `supply_ok` low, reset asserts. When `supply_ok` returns high, reset releases on the HOLD_TICKS-th ticking edge after that. A drop during the hold-off restarts the count.
- R3: With the chip-select pin held high and no kick, the watchdog asserts reset exactly P ticking edges after reset released, where P is the selected period.
- R4: A chip-select pin held low also times out after P ticks. Only the first qualified low interval counts as a kick.
- R5: Period code mapping on `wd_sel`: 2'b11 gives WD_SHORT_TICKS (200), 2'b10 gives WD_MID_TICKS (600), 2'b01 gives WD_LONG_TICKS (1400), and 2'b00 turns the watchdog off, so it never times out.
- R6: A kick is a low interval of at least KICK_MIN_CYC clock cycles (default 100) on `cs_wdi`. The watchdog count restarts at edge KICK_MIN_CYC+2 after the falling edge, which allows for the two synchroniser stages. A low pulse one cycle shorter is ignored.
- R7: A watchdog timeout holds reset asserted for HOLD_TICKS ticking edges. Release happens on the HOLD_TICKS-th edge after the timeout edge.
- R8: With ACTIVE_LOW=1, `sys_rst` is 0 while reset is asserted. With ACTIVE_LOW=0 it is 1 while reset is asserted. The timing is identical in both cases.
- R9: The watchdog count is held at zero while reset is asserted, and it starts counting on the first edge after release.
- R10: A change of `wd_sel` restarts the watchdog count on the next edge. The new period applies from that edge onward.
- R11: The watchdog and hold-off counters advance only on edges where `tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low logic reset |
| tick | input | 1 | Timebase strobe, one clock wide per tick |
| supply_ok | input | 1 | Digitised supply-good flag, synchronous to clk |
| cs_wdi | input | 1 | Chip-select / watchdog kick pin (asynchronous) |
| wd_sel | input | 2 | Watchdog period code from the status register |
| sys_rst | output | 1 | System reset, polarity set by ACTIVE_LOW |

## Verification
Reset asserts on the first edge after `supply_ok` drops. Release comes on the HOLD_TICKS-th ticking edge after supply recovers. A watchdog timeout lands exactly P ticking edges after release, or after a kick, or after a change of period code. A kick only takes effect KICK_MIN_CYC+2 edges after the pin falls, because of the two synchroniser flops and the width counter.

The bench steps a known number of edges and samples 1 ns after each edge. At every boundary it checks the last edge with the old value and the first edge with the new one. A second instance with the opposite polarity is compared on every check.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [1:0] {
        WD_OFF   = 2'b00,
        WD_LONG  = 2'b01,
        WD_MID   = 2'b10,
        WD_SHORT = 2'b11
    } wd_code_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sup_kick_filter.sv
module sup_kick_filter #(
    parameter int KICK_MIN_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_wdi,
    output logic kick
);
    localparam int LW = $clog2(KICK_MIN_CYC + 1);
    localparam logic [LW-1:0] LOW_LAST = LW'(KICK_MIN_CYC - 1);
    localparam logic [LW-1:0] LOW_SAT  = LW'(KICK_MIN_CYC);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic [LW-1:0] low;
    } filt_t;

    filt_t d, q;

    always_comb begin
        d    = q;
        d.s1 = cs_wdi;
        d.s2 = q.s1;
        if (q.s2)
            d.low = '0;
        else if (q.low != LOW_SAT)
            d.low = q.low + 1'b1;
        kick = !q.s2 && (q.low == LOW_LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.s1  <= 1'b1;
            q.s2  <= 1'b1;
            q.low <= '0;
        end else begin
            q <= d;
        end
    end

    // R6: one qualified kick per low interval
    a_r6_single_kick: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !kick);

    // R6: a kick is only ever seen while the synchronised pin is low
    a_r6_kick_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        kick |-> !q.s2);

endmodule

// File: rtl/sup_wdog.sv
module sup_wdog
    import sup_pkg::*;
#(
    parameter int WD_SHORT_TICKS = 200,
    parameter int WD_MID_TICKS   = 600,
    parameter int WD_LONG_TICKS  = 1400
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       hold_rst,
    input  logic [1:0] wd_sel,
    input  logic       kick,
    output logic       timeout
);
    localparam int CW = $clog2(max3(WD_SHORT_TICKS, WD_MID_TICKS, WD_LONG_TICKS) + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [1:0]    sel;
    } wd_t;

    wd_t d, q;
    logic [CW-1:0] last_m1;
    logic          enabled;
    logic          restart;

    always_comb begin
        case (wd_code_e'(wd_sel))
            WD_MID:  last_m1 = CW'(WD_MID_TICKS - 1);
            WD_LONG: last_m1 = CW'(WD_LONG_TICKS - 1);
            default: last_m1 = CW'(WD_SHORT_TICKS - 1);
        endcase
        enabled = (wd_sel != WD_OFF);
        restart = hold_rst || kick || (wd_sel != q.sel) || !enabled;
        timeout = !restart && tick && (q.cnt == last_m1);

        d     = q;
        d.sel = wd_sel;
        if (restart || timeout)
            d.cnt = '0;
        else if (tick)
            d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt <= '0;
            q.sel <= WD_SHORT;
        end else begin
            q <= d;
        end
    end

    // R9: count is cleared while system reset is held
    a_r9_clear_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        hold_rst |=> (q.cnt == '0));

    // R5: the off code never produces a timeout
    a_r5_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_sel == WD_OFF) |-> !timeout);

    // R10: a changed code restarts the count
    a_r10_code_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_sel != q.sel) |=> (q.cnt == '0));

    // R11: without a tick the count never advances
    a_r11_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (q.cnt == '0) || $stable(q.cnt));

endmodule

// File: rtl/sup_rst_hold.sv
module sup_rst_hold #(
    parameter int HOLD_TICKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic supply_ok,
    input  logic wd_trip,
    output logic rst_active
);
    localparam int HW = $clog2(HOLD_TICKS + 1);
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_TICKS - 1);

    typedef struct packed {
        logic          active;
        logic [HW-1:0] cnt;
    } hold_t;

    hold_t d, q;

    always_comb begin
        d = q;
        if (!supply_ok || wd_trip) begin
            d.active = 1'b1;
            d.cnt    = '0;
        end else if (q.active && tick) begin
            if (q.cnt == HOLD_LAST) begin
                d.active = 1'b0;
                d.cnt    = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
        rst_active = q.active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.active <= 1'b1;
            q.cnt    <= '0;
        end else begin
            q <= d;
        end
    end

    // R2: a bad supply forces reset on the next edge
    a_r2_supply_low: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> q.active);

    // R1: release only follows a good-supply edge
    a_r1_release_good: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.active) |-> $past(supply_ok));

    // R7: watchdog trip asserts reset on the next edge
    a_r7_trip_asserts: assert property (@(posedge clk) disable iff (!rst_n)
        wd_trip |=> q.active);

endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl #(
    parameter int HOLD_TICKS     = 200,
    parameter int WD_SHORT_TICKS = 200,
    parameter int WD_MID_TICKS   = 600,
    parameter int WD_LONG_TICKS  = 1400,
    parameter int KICK_MIN_CYC   = 100,
    parameter bit ACTIVE_LOW     = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       supply_ok,
    input  logic       cs_wdi,
    input  logic [1:0] wd_sel,
    output logic       sys_rst
);
    logic kick;
    logic timeout;
    logic rst_active;

    sup_kick_filter #(.KICK_MIN_CYC(KICK_MIN_CYC)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_wdi (cs_wdi),
        .kick   (kick)
    );

    sup_wdog #(
        .WD_SHORT_TICKS (WD_SHORT_TICKS),
        .WD_MID_TICKS   (WD_MID_TICKS),
        .WD_LONG_TICKS  (WD_LONG_TICKS)
    ) u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .hold_rst (rst_active),
        .wd_sel   (wd_sel),
        .kick     (kick),
        .timeout  (timeout)
    );

    sup_rst_hold #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .supply_ok  (supply_ok),
        .wd_trip    (timeout),
        .rst_active (rst_active)
    );

    generate
        if (ACTIVE_LOW) begin : g_low
            assign sys_rst = ~rst_active;
        end else begin : g_high
            assign sys_rst = rst_active;
        end
    endgenerate

endmodule

// File: tb/sim_sup_reset_ctrl.sv
module sim_sup_reset_ctrl;
    localparam int HOLD = 200;
    localparam int KMIN = 100;

    typedef struct packed {
        logic [1:0]  code;
        logic        cs;
        logic [11:0] period;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{code: 2'b11, cs: 1'b1, period: 12'd200},
        '{code: 2'b10, cs: 1'b1, period: 12'd600},
        '{code: 2'b01, cs: 1'b1, period: 12'd1400},
        '{code: 2'b11, cs: 1'b0, period: 12'd200},
        '{code: 2'b10, cs: 1'b0, period: 12'd600},
        '{code: 2'b00, cs: 1'b1, period: 12'd0}
    };

    logic clk = 1'b0;
    logic rst_n, tick, supply_ok, cs_wdi;
    logic [1:0] wd_sel;
    logic rst_lo, rst_hi;
    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    sup_reset_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok),
        .cs_wdi(cs_wdi), .wd_sel(wd_sel), .sys_rst(rst_lo)
    );

    sup_reset_ctrl #(.ACTIVE_LOW(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok),
        .cs_wdi(cs_wdi), .wd_sel(wd_sel), .sys_rst(rst_hi)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // expected: 1 = reset asserted; checks both polarities (R8)
    task automatic chk_rst(input string tag, input bit exp_on);
        logic [1:0] got, exp;
        got = {rst_lo, rst_hi};
        exp = exp_on ? 2'b01 : 2'b10;
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s (R8 pair lo/hi): got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic chk_int(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic wait_release(output int edges);
        edges = 0;
        while (rst_lo !== 1'b1 && edges < 5000) begin
            step(1);
            edges++;
        end
    endtask

    task automatic fresh(input string tag);
        int e;
        supply_ok = 1'b0;
        step(1);
        supply_ok = 1'b1;
        wait_release(e);
        chk_int(tag, e, HOLD);
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int e;
        rst_n = 1'b0; tick = 1'b1; supply_ok = 1'b1; cs_wdi = 1'b1; wd_sel = 2'b11;
        step(5);
        chk_rst("R1 reset state", 1'b1);
        rst_n = 1'b1;
        step(HOLD - 1);
        chk_rst("R1 power-up hold not yet over", 1'b1);
        step(1);
        chk_rst("R1 power-up release", 1'b0);

        // vector table: period per code and pin level
        for (int i = 0; i < 6; i++) begin
            wd_sel = VECS[i].code;
            cs_wdi = VECS[i].cs;
            fresh("R2 hold-off length");
            if (VECS[i].period != 0) begin
                step(int'(VECS[i].period) - 1);
                chk_rst(VECS[i].cs ? "R9 R3 no early timeout" : "R9 R4 no early timeout", 1'b0);
                step(1);
                chk_rst(VECS[i].cs ? "R3 R5 timeout pin high" : "R4 R5 timeout pin low", 1'b1);
            end else begin
                step(3000);
                chk_rst("R5 code off never times out", 1'b0);
            end
        end

        // R6 valid kick: low for KMIN cycles
        wd_sel = 2'b11; cs_wdi = 1'b1;
        fresh("R2 hold-off length");
        step(50); cs_wdi = 1'b0;
        step(KMIN); cs_wdi = 1'b1;
        step(201);
        chk_rst("R6 kick restarted count", 1'b0);
        step(1);
        chk_rst("R6 timeout after kick", 1'b1);

        // R6 short pulse ignored, then R7 hold-off after trip
        fresh("R2 hold-off length");
        step(50); cs_wdi = 1'b0;
        step(KMIN - 1); cs_wdi = 1'b1;
        step(50);
        chk_rst("R6 short pulse ignored", 1'b0);
        step(1);
        chk_rst("R6 timeout despite short pulse", 1'b1);
        step(HOLD - 1);
        chk_rst("R7 trip hold-off not over", 1'b1);
        step(1);
        chk_rst("R7 trip hold-off release", 1'b0);

        // R10 code change restarts with new period
        wd_sel = 2'b11;
        fresh("R2 hold-off length");
        step(150); wd_sel = 2'b10;
        step(600);
        chk_rst("R10 new period in force", 1'b0);
        step(1);
        chk_rst("R10 timeout at new period", 1'b1);

        // R11 tick gating
        wd_sel = 2'b11;
        fresh("R2 hold-off length");
        tick = 1'b0;
        step(300);
        chk_rst("R11 no count without tick", 1'b0);
        tick = 1'b1;
        step(199);
        chk_rst("R11 count resumes", 1'b0);
        step(1);
        chk_rst("R11 timeout after gated ticks", 1'b1);

        // R2 brown-out and glitch during hold-off
        fresh("R2 hold-off length");
        step(10); supply_ok = 1'b0;
        step(1);
        chk_rst("R2 supply drop asserts", 1'b1);
        step(20);
        supply_ok = 1'b1;
        step(100); supply_ok = 1'b0;
        step(1);
        chk_rst("R2 glitch during hold-off", 1'b1);
        supply_ok = 1'b1;
        wait_release(e);
        chk_int("R2 hold-off restarted", e, HOLD);

        // R6 regular kicks keep reset released
        for (int k = 0; k < 10; k++) begin
            step(80); cs_wdi = 1'b0;
            step(KMIN); cs_wdi = 1'b1;
        end
        chk_rst("R6 periodic kicks prevent reset", 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule